// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Aligned Updates

This peripheral drives four independent pulse-width-modulated outputs from one clock. A plain register bus (address, write data, write strobe, combinational read data) reaches two groups of registers. The first group is global: a start mask, a stop mask and a running-channel status word. The second is one register bank per channel: a mode word, a duty value, a period value and an update port. Each channel divides the input clock by a power of two, runs a counter from zero up to period minus one, and drives its output active while the counter is below duty. A polarity bit can invert the output.

Duty and period are loaded directly while a channel is stopped. While it runs, those two registers are locked. New values go through the update port: a written value waits in a shadow register and is copied into duty or period only when the counter wraps. The target is picked by a bit in the mode word. A change therefore never cuts a pulse short or stretches it.

Top module: `multi_pwm_ctrl`

## Requirements
- R1: After reset every mode, duty and period register reads zero, the status word reads zero and all four outputs are low.
- R2: A write to address 0x04 starts each channel n whose data bit n is 1. A write to 0x08 stops each such channel. Zero bits leave their channels as they were. Reading 0x0C returns the running mask in bits 3:0 and zeros above.
- R3: Channel n's bank starts at 0x200 + n*0x20. Inside the bank, mode is at offset 0x00, duty at 0x04, period at 0x08 and the update port at 0x10. Duty and period keep only data bits 15:0, and their bits 31:16 read as zero.
- R4: A running channel's counter begins at zero on the start write. It steps once per prescaled tick and wraps to zero after period-1. The raw output is high while the counter is below duty.
- R5: Mode bits 3:0 hold a prescale exponent p. The counter advances once every 2^p input clocks. A value above 10 behaves as 10 but reads back as written.
- R6: Mode bit 9 set inverts the output. A stopped channel drives the inactive level: the value of bit 9.
- R7: Writes to the duty or period register of a running channel are ignored.
- R8: A write to the update port is held and copied at the next counter wrap of the running channel. It goes into duty when mode bit 10 was 0 at the time of the write, and into period when it was 1. Until that wrap, duty and period read their old values.
- R9: A period of zero keeps the output at its inactive level. A duty at or above the period keeps it active for the whole cycle.
- R10: Stopping a channel clears its counter and prescaler. A later start begins a fresh period from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRData | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 4 | One modulated output per channel |

## Verification
A behavioural model tracks every channel's counter, prescaler and pending shadow value. It is compared with all four outputs on every clock, while directed scenarios probe the corners.

- An update written mid-period must leave the read-back duty untouched until the wrap. A design that copies it at once would show a runt pulse and an early read-back value.
- A period shrunk through the update port must take effect only after the full old period.
- Period zero and duty above period must pin the output. An off-by-one compare would show a one-cycle glitch.
- Exponents above 10 must clamp rather than wrap the divider.
- A restart after a stop must begin a whole new period. A design that kept its old counter would start mid-cycle.
- A locked duty write while running must not leak through.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 4;
  localparam int PRE_MAX   = 10;
  localparam int DIV_W     = PRE_MAX;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int A_START   = 'h04;
  localparam int A_STOP    = 'h08;
  localparam int A_STAT    = 'h0C;
  localparam int CH_BASE   = 'h200;
  localparam int CH_STRIDE = 'h20;
  localparam int O_MODE    = 'h00;
  localparam int O_DUTY    = 'h04;
  localparam int O_PRD     = 'h08;
  localparam int O_UPD     = 'h10;
  localparam int POL_BIT   = 9;
  localparam int SEL_BIT   = 10;

  typedef struct packed {
    logic             run;
    logic [PRE_W-1:0] preExp;
    logic             pol;
    logic             dutyWr;
    logic             prdWr;
    logic             updWr;
    logic             updSel;
    logic [CNT_W-1:0] wrVal;
  } chanCmd_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWData,
  input  logic                        busWrEn,
  input  logic [NCH-1:0][CNT_W-1:0]   dutyVec,
  input  logic [NCH-1:0][CNT_W-1:0]   prdVec,
  output chanCmd_t [NCH-1:0]          cmd,
  output logic [NCH-1:0]              runVec,
  output logic [DATA_W-1:0]           busRData
);
  localparam int STR_SH   = $clog2(CH_STRIDE);
  localparam int CH_W     = $clog2(NCH);
  localparam int BANK_END = CH_BASE + NCH * CH_STRIDE;

  logic [NCH-1:0]            runQ;
  logic [NCH-1:0][PRE_W-1:0] modePre;
  logic [NCH-1:0]            modePol;
  logic [NCH-1:0]            modeSel;

  logic              inBank;
  logic [ADDR_W-1:0] relAddr;
  logic [CH_W-1:0]   chSel;
  logic [STR_SH-1:0] regOff;

  assign inBank  = (busAddr >= ADDR_W'(CH_BASE)) && (busAddr < ADDR_W'(BANK_END));
  assign relAddr = busAddr - ADDR_W'(CH_BASE);
  assign chSel   = relAddr[STR_SH +: CH_W];
  assign regOff  = relAddr[STR_SH-1:0];
  assign runVec  = runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (busWrEn && busAddr == ADDR_W'(A_START)) begin
      runQ <= runQ | busWData[NCH-1:0];
    end else if (busWrEn && busAddr == ADDR_W'(A_STOP)) begin
      runQ <= runQ & ~busWData[NCH-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic bankHit;
    assign bankHit = busWrEn && inBank && (chSel == CH_W'(ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modePre[ch] <= '0;
        modePol[ch] <= 1'b0;
        modeSel[ch] <= 1'b0;
      end else if (bankHit && regOff == STR_SH'(O_MODE)) begin
        modePre[ch] <= busWData[PRE_W-1:0];
        modePol[ch] <= busWData[POL_BIT];
        modeSel[ch] <= busWData[SEL_BIT];
      end
    end

    always_comb begin
      cmd[ch].run    = runQ[ch];
      cmd[ch].preExp = (modePre[ch] > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : modePre[ch];
      cmd[ch].pol    = modePol[ch];
      cmd[ch].dutyWr = bankHit && (regOff == STR_SH'(O_DUTY)) && !runQ[ch];
      cmd[ch].prdWr  = bankHit && (regOff == STR_SH'(O_PRD)) && !runQ[ch];
      cmd[ch].updWr  = bankHit && (regOff == STR_SH'(O_UPD));
      cmd[ch].updSel = modeSel[ch];
      cmd[ch].wrVal  = busWData[CNT_W-1:0];
    end
  end

  always_comb begin
    busRData = '0;
    if (busAddr == ADDR_W'(A_STAT)) begin
      busRData[NCH-1:0] = runQ;
    end else if (inBank) begin
      if (regOff == STR_SH'(O_MODE)) begin
        busRData[PRE_W-1:0] = modePre[chSel];
        busRData[POL_BIT]   = modePol[chSel];
        busRData[SEL_BIT]   = modeSel[chSel];
      end else if (regOff == STR_SH'(O_DUTY)) begin
        busRData[CNT_W-1:0] = dutyVec[chSel];
      end else if (regOff == STR_SH'(O_PRD)) begin
        busRData[CNT_W-1:0] = prdVec[chSel];
      end
    end
  end
endmodule

// File: rtl/mpwm_chan_dp.sv
module mpwm_chan_dp
  import mpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCmd_t         cmd,
  output logic [CNT_W-1:0] dutyQ,
  output logic [CNT_W-1:0] prdQ,
  output logic             pwmOut
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shadowQ;
  logic             pendQ;
  logic             pendSelQ;
  logic             tick;
  logic             wrap;
  logic             rawHigh;

  assign divLim  = DIV_W'((32'd1 << cmd.preExp) - 32'd1);
  assign tick    = divCnt >= divLim;
  assign wrap    = (prdQ == '0) ||
                   (({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, prdQ});
  assign rawHigh = cmd.run && (prdQ != '0) && (cnt < dutyQ);
  assign pwmOut  = rawHigh ^ cmd.pol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      cnt      <= '0;
      dutyQ    <= '0;
      prdQ     <= '0;
      shadowQ  <= '0;
      pendQ    <= 1'b0;
      pendSelQ <= 1'b0;
    end else begin
      if (!cmd.run) begin
        divCnt <= '0;
        cnt    <= '0;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (wrap) begin
            cnt <= '0;
            if (pendQ) begin
              pendQ <= 1'b0;
              if (pendSelQ) prdQ <= shadowQ;
              else          dutyQ <= shadowQ;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (cmd.dutyWr) dutyQ <= cmd.wrVal;
      if (cmd.prdWr)  prdQ  <= cmd.wrVal;
      if (cmd.updWr) begin
        shadowQ  <= cmd.wrVal;
        pendQ    <= 1'b1;
        pendSelQ <= cmd.updSel;
      end
    end
  end
endmodule

// File: rtl/multi_pwm_ctrl.sv
module multi_pwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       busAddr,
  input  logic [31:0]       busWData,
  input  logic              busWrEn,
  output logic [31:0]       busRData,
  output logic [NCH-1:0]    pwmOut
);
  chanCmd_t [NCH-1:0]        cmd;
  logic [NCH-1:0][CNT_W-1:0] dutyVec;
  logic [NCH-1:0][CNT_W-1:0] prdVec;
  logic [NCH-1:0]            runVec;
  logic [NCH-1:0]            polVec;

  mpwm_ctrl #(.NCH(NCH)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWData(busWData),
    .busWrEn (busWrEn),
    .dutyVec (dutyVec),
    .prdVec  (prdVec),
    .cmd     (cmd),
    .runVec  (runVec),
    .busRData(busRData)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dp
    assign polVec[ch] = cmd[ch].pol;
    mpwm_chan_dp dp_i (
      .clk   (clk),
      .rstN  (rstN),
      .cmd   (cmd[ch]),
      .dutyQ (dutyVec[ch]),
      .prdQ  (prdVec[ch]),
      .pwmOut(pwmOut[ch])
    );
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk
  import mpwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [11:0]               busAddr,
  input logic [31:0]               busWData,
  input logic                      busWrEn,
  input logic [31:0]               busRData,
  input logic [NCH-1:0]            pwmOut,
  input logic [NCH-1:0]            runVec,
  input logic [NCH-1:0]            polVec,
  input logic [NCH-1:0][CNT_W-1:0] prdVec
);
  logic        startWr;
  logic        stopWr;
  logic        valueRd;
  logic [11:0] rel;

  assign startWr = busWrEn && busAddr == 12'(A_START);
  assign stopWr  = busWrEn && busAddr == 12'(A_STOP);
  assign rel     = busAddr - 12'(CH_BASE);
  assign valueRd = (busAddr >= 12'(CH_BASE)) && (busAddr < 12'(CH_BASE + NCH * CH_STRIDE)) &&
                   (rel[4:0] == 5'(O_DUTY) || rel[4:0] == 5'(O_PRD));

  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> ((runVec & $past(busWData[NCH-1:0])) == $past(busWData[NCH-1:0])));

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> ((runVec & $past(busWData[NCH-1:0])) == '0));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    valueRd |-> (busRData[31:16] == 16'h0));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[ch] |-> (pwmOut[ch] == polVec[ch]));

    a_r9_zero_period: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[ch] && prdVec[ch] == '0) |-> (pwmOut[ch] == polVec[ch]));
  end
endmodule

bind multi_pwm_ctrl mpwm_chk #(.NCH(NCH)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWData(busWData),
  .busWrEn (busWrEn),
  .busRData(busRData),
  .pwmOut  (pwmOut),
  .runVec  (runVec),
  .polVec  (polVec),
  .prdVec  (prdVec)
);

// File: tb/multi_pwm_ctrl_tb_top.sv
module multi_pwm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busRData;
  logic [3:0]  pwmOut;

  int testCnt = 0;
  int failCnt = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural model state
  int mRun[4], mDiv[4], mCnt[4], mDuty[4], mPrd[4];
  int mSh[4], mPend[4], mPsel[4], mPre[4], mPol[4], mSel[4];

  multi_pwm_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData),
    .busWrEn(busWrEn), .busRData(busRData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expOut(int ch);
    int raw;
    raw = (mRun[ch] != 0 && mPrd[ch] != 0 && mCnt[ch] < mDuty[ch]) ? 1 : 0;
    return raw ^ mPol[ch];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mRun[c] = 0; mDiv[c] = 0; mCnt[c] = 0; mDuty[c] = 0; mPrd[c] = 0;
        mSh[c] = 0; mPend[c] = 0; mPsel[c] = 0; mPre[c] = 0; mPol[c] = 0; mSel[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (mRun[c] == 0) begin
          mDiv[c] = 0; mCnt[c] = 0;
        end else begin
          int e, lim;
          e = (mPre[c] > 10) ? 10 : mPre[c];
          lim = (1 << e) - 1;
          if (mDiv[c] >= lim) begin
            mDiv[c] = 0;
            if (mPrd[c] == 0 || mCnt[c] + 1 >= mPrd[c]) begin
              mCnt[c] = 0;
              if (mPend[c] != 0) begin
                if (mPsel[c] != 0) mPrd[c] = mSh[c];
                else mDuty[c] = mSh[c];
                mPend[c] = 0;
              end
            end else begin
              mCnt[c] = mCnt[c] + 1;
            end
          end else begin
            mDiv[c] = mDiv[c] + 1;
          end
        end
      end
      if (busWrEn) begin
        int a, w;
        a = int'(busAddr);
        w = int'(busWData);
        if (a == 'h04) begin
          for (int c = 0; c < 4; c++) if (w[c]) mRun[c] = 1;
        end else if (a == 'h08) begin
          for (int c = 0; c < 4; c++) if (w[c]) mRun[c] = 0;
        end else if (a >= 'h200 && a < 'h280) begin
          int c, off;
          c = (a - 'h200) / 32;
          off = (a - 'h200) % 32;
          if (off == 0) begin
            mPre[c] = w & 15; mPol[c] = (w >> 9) & 1; mSel[c] = (w >> 10) & 1;
          end else if (off == 4 && mRun[c] == 0) mDuty[c] = w & 'hFFFF;
          else if (off == 8 && mRun[c] == 0) mPrd[c] = w & 'hFFFF;
          else if (off == 16) begin
            mSh[c] = w & 'hFFFF; mPend[c] = 1; mPsel[c] = mSel[c];
          end
        end
      end
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 4; c++) begin
        testCnt++;
        if (int'(pwmOut[c]) != expOut(c)) begin
          failCnt++;
          $display("FAIL %s pwmOut[%0d] actual %0d expected %0d at cycle %0d",
                   curReq, c, pwmOut[c], expOut(c), cycles);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      failCnt++;
      $display("FAIL watchdog expired, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(int a, int d);
    @(negedge clk);
    busAddr = 12'(a); busWData = 32'(d); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int a, output int d);
    @(negedge clk);
    busAddr = 12'(a);
    #1 d = int'(busRData);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bank(int ch, int off);
    return 'h200 + ch * 'h20 + off;
  endfunction

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    busRead('h0C, rd); check("R1 status", rd, 0);
    for (int c = 0; c < 4; c++) begin
      busRead(bank(c, 'h00), rd); check("R1 mode", rd, 0);
      busRead(bank(c, 'h04), rd); check("R1 duty", rd, 0);
      busRead(bank(c, 'h08), rd); check("R1 period", rd, 0);
    end
    check("R1 outputs", int'(pwmOut), 0);

    // R3: bank addressing and 16-bit value registers
    curReq = "R3";
    busWrite(bank(1, 'h04), 'hABCD1234);
    busRead(bank(1, 'h04), rd); check("R3 duty ch1 low bits", rd, 'h1234);
    busWrite(bank(3, 'h08), 'h00770009);
    busRead(bank(3, 'h08), rd); check("R3 period ch3", rd, 'h0009);
    busRead(bank(2, 'h08), rd); check("R3 period ch2 untouched", rd, 0);
    busWrite(bank(1, 'h04), 0);
    busWrite(bank(3, 'h08), 0);

    // R2: start and stop masks
    curReq = "R2";
    busWrite('h04, 'h1);
    busWrite('h04, 'h4);
    busRead('h0C, rd); check("R2 status after two starts", rd, 'h5);
    busWrite('h08, 'h1);
    busRead('h0C, rd); check("R2 status after stop", rd, 'h4);
    busWrite('h08, 'hF);
    busRead('h0C, rd); check("R2 status all stopped", rd, 0);

    // R4: basic counting on ch0, duty 3 period 8
    curReq = "R4";
    busWrite(bank(0, 'h04), 3);
    busWrite(bank(0, 'h08), 8);
    busWrite('h04, 'h1);
    check("R4 output active at period start", int'(pwmOut[0]), 1);
    idle(40);

    // R7: direct writes ignored while running
    curReq = "R7";
    busWrite(bank(0, 'h04), 7);
    busRead(bank(0, 'h04), rd); check("R7 duty locked", rd, 3);
    busWrite(bank(0, 'h08), 2);
    busRead(bank(0, 'h08), rd); check("R7 period locked", rd, 8);
    idle(10);

    // R8: buffered update into duty then into period
    curReq = "R8";
    busWrite(bank(0, 'h10), 5);
    busRead(bank(0, 'h04), rd); check("R8 duty before wrap", rd, 3);
    idle(12);
    busRead(bank(0, 'h04), rd); check("R8 duty after wrap", rd, 5);
    busWrite(bank(0, 'h00), 1 << 10);
    busWrite(bank(0, 'h10), 6);
    busRead(bank(0, 'h08), rd); check("R8 period before wrap", rd, 8);
    idle(12);
    busRead(bank(0, 'h08), rd); check("R8 period after wrap", rd, 6);
    busRead(bank(0, 'h04), rd); check("R8 duty kept", rd, 5);
    idle(20);

    // R10: stop and restart
    curReq = "R10";
    busWrite('h08, 'h1);
    check("R10 stopped output inactive", int'(pwmOut[0]), 0);
    idle(5);
    busWrite('h04, 'h1);
    check("R10 restart from zero", int'(pwmOut[0]), 1);
    idle(20);

    // R5: prescaler on ch1 (p=2) and clamp on ch2 (p=15)
    curReq = "R5";
    busWrite(bank(1, 'h00), 2);
    busWrite(bank(1, 'h04), 2);
    busWrite(bank(1, 'h08), 4);
    busWrite('h04, 'h2);
    idle(64);
    busWrite('h08, 'h2);
    busWrite(bank(2, 'h00), 15);
    busRead(bank(2, 'h00), rd); check("R5 exponent reads as written", rd, 15);
    busWrite(bank(2, 'h04), 1);
    busWrite(bank(2, 'h08), 2);
    busWrite('h04, 'h4);
    idle(1020);
    check("R5 still high before 1024 clocks", int'(pwmOut[2]), 1);
    idle(1100);
    busWrite('h08, 'h4);

    // R9: period zero and duty above period on ch1
    curReq = "R9";
    busWrite(bank(1, 'h00), 0);
    busWrite(bank(1, 'h08), 0);
    busWrite(bank(1, 'h04), 5);
    busWrite('h04, 'h2);
    idle(20);
    check("R9 zero period inactive", int'(pwmOut[1]), 0);
    busWrite('h08, 'h2);
    busWrite(bank(1, 'h08), 4);
    busWrite(bank(1, 'h04), 9);
    busWrite('h04, 'h2);
    idle(20);
    check("R9 duty above period active", int'(pwmOut[1]), 1);

    // R6: polarity inversion on ch3
    curReq = "R6";
    busWrite(bank(3, 'h00), 1 << 9);
    check("R6 idle level follows polarity", int'(pwmOut[3]), 1);
    busWrite(bank(3, 'h04), 1);
    busWrite(bank(3, 'h08), 3);
    busWrite('h04, 'h8);
    check("R6 inverted active phase", int'(pwmOut[3]), 0);
    idle(30);
    busWrite('h08, 'hF);
    idle(4);
    check("R6 all stopped", int'(pwmOut), 'h8);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule